// File: doc/BRIEF.md
# Serial Signed-Fraction Arithmetic Unit

This unit adds, subtracts and multiplies signed binary fractions that arrive one bit per clock. A word is WORD_W = FRAC_W + 1 bits wide: a sign bit with FRAC_W fraction bits below it. The binary point sits just right of the sign, so a word with integer pattern v has the value v / 2^FRAC_W and lies in [-1, 1). Inside the unit, negative values are held in two's complement. Both operands enter on two serial pins, least significant bit first. The result leaves on one serial pin in the same order, framed by a valid strobe. A one-cycle completion pulse follows the result.

After every operation the unit keeps the sign of the result and a sticky overflow indication. Sequencing logic outside the unit can use the kept sign to choose between two words. A start strobe is taken only while the unit is idle. It latches the opcode, clears the overflow flag and opens an operand window of WORD_W cycles.

Add and subtract produce each result bit one cycle after the matching operand bits arrive. Multiply first collects both words. It then accumulates one partial product per cycle for WORD_W cycles, and after that shifts the product out.

Top module: `serial_frac_alu`

## Requirements
- R1: While reset is low and in the first cycle after it is released, busy, done and r_valid are 0, and sign_flag and ovf_flag are 0.
- R2: With op = 2'b00 the result is a + b modulo 2^WORD_W. It is emitted as WORD_W consecutive r_valid bits, least significant bit first. Bit i leaves one cycle after operand bit i is sampled.
- R3: With op = 2'b01 the result is a - b modulo 2^WORD_W, with the same framing as R2.
- R4: For add and subtract, ovf_flag reads 1 when done is high if the exact sum or difference lies outside [-1, 1 - 2^-FRAC_W]. Otherwise it reads 0.
- R5: With op[1] = 1 (2'b10 or 2'b11) the result is the lower WORD_W bits of floor(a*b / 2^FRAC_W), which keeps the upper product bits and truncates toward minus infinity. ovf_flag reads 1 only for (-1) x (-1), whose result wraps to the pattern of -1.
- R6: sign_flag equals bit WORD_W-1 of the last result. It changes only in the cycle in which done is high, and it holds until the next done.
- R7: done is high for exactly one cycle, the cycle after the last result bit, with r_valid low. Counting cycles from the edge that accepts start, done appears WORD_W+2 cycles later for add and subtract and 3*WORD_W+2 cycles later for multiply.
- R8: ovf_flag is cleared by an accepted start and keeps its value between that start and the following done.
- R9: start is accepted only while busy is low. A start (with any opcode) during an operation changes neither the result nor the flags of that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | synchronous active-low reset |
| start | input | 1 | begin an operation (taken only while idle) |
| op | input | 2 | 00 add, 01 subtract, 1x multiply; sampled with start |
| a_bit | input | 1 | serial operand a, LSB first, one bit per cycle after start |
| b_bit | input | 1 | serial operand b, LSB first, aligned with a_bit |
| r_bit | output | 1 | serial result, LSB first |
| r_valid | output | 1 | r_bit carries a result bit |
| done | output | 1 | one-cycle completion pulse |
| busy | output | 1 | operation in progress |
| sign_flag | output | 1 | sign of the last result |
| ovf_flag | output | 1 | overflow of the last operation (sticky within it) |

## Verification
A wrong carry or borrow state in the adder shows in the very next result bit. The wrong value then ripples up to the sign, so sign_flag and ovf_flag are wrong at done as well. A slip in the phase counter moves the done pulse off its fixed latency and changes the number of r_valid bits in that frame. Because the multiplier is stepped one partial product per cycle, a wrong accumulator or shift step does not show until the draining phase, about 2*WORD_W cycles after start. It then usually appears in the upper result bits and in the sign. The bench scores every frame against a queued model result and checks the done latency and the flags at every done.

// File: rtl/sfa_pkg.sv
// Shared types of the serial signed-fraction arithmetic unit.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package sfa_pkg;

    // Phases of one operation, in the order they run.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LOAD  = 3'd1,
        PH_CALC  = 3'd2,
        PH_DRAIN = 3'd3,
        PH_TAIL  = 3'd4,
        PH_FIN   = 3'd5
    } phase_t;

    // Opcode bit positions: bit 1 selects multiply, bit 0 selects subtract.
    localparam int unsigned OP_MUL_BIT = 1;
    localparam int unsigned OP_SUB_BIT = 0;

endpackage

// File: rtl/sfa_seq.sv
// Phase sequencer: counts bit-times and steps through load, calculate,
// drain, tail and finish phases.
// Assumes: is_mul is stable from the accepting edge until the op ends.
module sfa_seq
    import sfa_pkg::*;
#(
    parameter int unsigned WORD_W = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic is_mul,
    output logic accept,
    output logic load_en,
    output logic calc_en,
    output logic drain_en,
    output logic tail_en,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    phase_t           phase_q;
    phase_t           phase_d;
    logic [CNT_W-1:0] cnt_q;
    logic             counting;

    assign accept   = start && (phase_q == PH_IDLE);
    assign load_en  = (phase_q == PH_LOAD);
    assign calc_en  = (phase_q == PH_CALC);
    assign drain_en = (phase_q == PH_DRAIN);
    assign tail_en  = (phase_q == PH_TAIL);
    assign done     = (phase_q == PH_FIN);
    assign busy     = (phase_q != PH_IDLE);
    assign last     = (cnt_q == CNT_LAST);
    assign counting = load_en || calc_en || drain_en;

    // Next-phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:  if (start) phase_d = PH_LOAD;
            PH_LOAD:  if (last)  phase_d = is_mul ? PH_CALC : PH_TAIL;
            PH_CALC:  if (last)  phase_d = PH_DRAIN;
            PH_DRAIN: if (last)  phase_d = PH_TAIL;
            PH_TAIL:             phase_d = PH_FIN;
            PH_FIN:              phase_d = PH_IDLE;
            default:             phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Bit-time counter: runs in counted phases, wraps at the word end.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (accept)           cnt_q <= '0;
        else if (counting && last) cnt_q <= '0;
        else if (counting)         cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/sfa_addsub.sv
// Bit-serial adder/subtractor with a carry flip-flop between bit-times.
// Subtract inverts b and seeds the carry with 1. Overflow is the carry
// into the sign position XOR the carry out of it.
// Assumes: init pulses once before the first en; bits arrive LSB first.
module sfa_addsub (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic sub_in,
    input  logic en,
    input  logic last,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_bit,
    output logic ovf
);
    logic carry_q;
    logic sub_q;
    logic ovf_q;
    logic b_eff;
    logic cout;

    assign b_eff   = b_bit ^ sub_q;
    assign sum_bit = a_bit ^ b_eff ^ carry_q;
    assign cout    = (a_bit & b_eff) | (a_bit & carry_q) | (b_eff & carry_q);
    assign ovf     = ovf_q;

    // Carry chain state and operation mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
            sub_q   <= 1'b0;
        end else if (init) begin
            carry_q <= sub_in;
            sub_q   <= sub_in;
        end else if (en) begin
            carry_q <= cout;
        end
    end

    // Signed overflow capture on the sign bit-time.
    always_ff @(posedge clk) begin
        if (!rst_n)            ovf_q <= 1'b0;
        else if (init)         ovf_q <= 1'b0;
        else if (en && last)   ovf_q <= carry_q ^ cout;
    end

endmodule

// File: rtl/sfa_mul.sv
// Signed fractional multiplier: collects both words serially, adds one
// shifted partial product per cycle (subtracting the one at the sign
// weight), then shifts the upper WORD_W product bits out LSB first.
// Assumes: load, calc and drain each last exactly WORD_W enabled cycles.
module sfa_mul #(
    parameter int unsigned WORD_W = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic load_en,
    input  logic calc_en,
    input  logic drain_en,
    input  logic last,
    input  logic a_bit,
    input  logic b_bit,
    output logic out_bit,
    output logic ovf
);
    localparam int unsigned ACC_W = 2 * WORD_W;

    logic        [WORD_W-1:0] a_sr;
    logic        [WORD_W-1:0] b_sr;
    logic        [ACC_W-1:0]  mcand;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  acc_next;
    logic        [ACC_W-1:0]  partial;
    logic                     ovf_q;

    assign partial  = b_sr[0] ? mcand : '0;
    assign acc_next = last ? (acc - $signed(partial)) : (acc + $signed(partial));
    assign out_bit  = acc[WORD_W-1];
    assign ovf      = ovf_q;

    // Operand shift registers: fill from the top, consume multiplier bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_sr <= '0;
            b_sr <= '0;
        end else if (load_en) begin
            a_sr <= {a_bit, a_sr[WORD_W-1:1]};
            b_sr <= {b_bit, b_sr[WORD_W-1:1]};
        end else if (calc_en) begin
            b_sr <= {1'b0, b_sr[WORD_W-1:1]};
        end
    end

    // Sign-extended multiplicand, shifted one place per partial product.
    always_ff @(posedge clk) begin
        if (!rst_n)                mcand <= '0;
        else if (load_en && last)  mcand <= {{WORD_W{a_bit}}, a_bit, a_sr[WORD_W-1:1]};
        else if (calc_en)          mcand <= {mcand[ACC_W-2:0], 1'b0};
    end

    // Accumulator: add partial products, then shift right while draining.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc <= '0;
        else if (init)     acc <= '0;
        else if (calc_en)  acc <= acc_next;
        else if (drain_en) acc <= acc >>> 1;
    end

    // Product overflow: the two top accumulator bits disagree.
    always_ff @(posedge clk) begin
        if (!rst_n)               ovf_q <= 1'b0;
        else if (init)            ovf_q <= 1'b0;
        else if (calc_en && last) ovf_q <= acc_next[ACC_W-1] ^ acc_next[ACC_W-2];
    end

endmodule

// File: rtl/serial_frac_alu.sv
// Serial signed-fraction arithmetic unit, top level. Routes serial
// operands to the adder or the multiplier, frames the result stream and
// keeps the result sign and a sticky overflow flag.
// Assumes: operand bit i is present at the (i+1)-th edge after start is
// accepted.
module serial_frac_alu
    import sfa_pkg::*;
#(
    parameter int unsigned FRAC_W = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] op,
    input  logic       a_bit,
    input  logic       b_bit,
    output logic       r_bit,
    output logic       r_valid,
    output logic       done,
    output logic       busy,
    output logic       sign_flag,
    output logic       ovf_flag
);
    localparam int unsigned WORD_W = FRAC_W + 1;

    logic accept, load_en, calc_en, drain_en, tail_en, last;
    logic mul_q;
    logic op_sub;
    logic add_bit, add_ovf;
    logic mul_bit, mul_ovf;
    logic emit;
    logic r_bit_q, r_valid_q, sign_q, ovf_q;

    assign op_sub = op[OP_SUB_BIT] & ~op[OP_MUL_BIT];
    assign emit   = (load_en && !mul_q) || drain_en;

    sfa_seq #(.WORD_W(WORD_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_mul   (mul_q),
        .accept   (accept),
        .load_en  (load_en),
        .calc_en  (calc_en),
        .drain_en (drain_en),
        .tail_en  (tail_en),
        .last     (last),
        .busy     (busy),
        .done     (done)
    );

    sfa_addsub u_addsub (
        .clk     (clk),
        .rst_n   (rst_n),
        .init    (accept),
        .sub_in  (op_sub),
        .en      (load_en && !mul_q),
        .last    (last),
        .a_bit   (a_bit),
        .b_bit   (b_bit),
        .sum_bit (add_bit),
        .ovf     (add_ovf)
    );

    sfa_mul #(.WORD_W(WORD_W)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (accept),
        .load_en  (load_en && mul_q),
        .calc_en  (calc_en),
        .drain_en (drain_en),
        .last     (last),
        .a_bit    (a_bit),
        .b_bit    (b_bit),
        .out_bit  (mul_bit),
        .ovf      (mul_ovf)
    );

    // Latch the operation kind when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)      mul_q <= 1'b0;
        else if (accept) mul_q <= op[OP_MUL_BIT];
    end

    // Result bit register and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_bit_q   <= 1'b0;
            r_valid_q <= 1'b0;
        end else begin
            r_valid_q <= emit;
            if (emit) r_bit_q <= mul_q ? mul_bit : add_bit;
        end
    end

    // Result sign and sticky overflow, committed on the tail bit-time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (accept) begin
            ovf_q  <= 1'b0;
        end else if (tail_en) begin
            sign_q <= r_bit_q;
            ovf_q  <= ovf_q | (mul_q ? mul_ovf : add_ovf);
        end
    end

    assign r_bit     = r_bit_q;
    assign r_valid   = r_valid_q;
    assign sign_flag = sign_q;
    assign ovf_flag  = ovf_q;

endmodule

// File: rtl/sfa_checker.sv
// Protocol checker for serial_frac_alu, attached with bind.
// Assumes: synchronous active-low reset on rst_n.
module sfa_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic r_valid,
    input logic done,
    input logic busy,
    input logic sign_flag,
    input logic ovf_flag
);
    // R7: completion is a single-cycle pulse.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: no result bit is framed in the completion cycle.
    p_done_no_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !r_valid);

    // R6: the kept sign moves only together with completion.
    p_sign_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sign_flag) |-> done);

    // R8: an accepted start clears the overflow flag.
    p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !ovf_flag);

    // R4: overflow can only appear at completion.
    p_ovf_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> done);

    // R9: an idle start makes the unit busy without completing.
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

endmodule

bind serial_frac_alu sfa_checker u_sfa_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .r_valid   (r_valid),
    .done      (done),
    .busy      (busy),
    .sign_flag (sign_flag),
    .ovf_flag  (ovf_flag)
);

// File: tb/serial_frac_alu_bench.sv
// Scoreboard bench: the driver queues model results, the monitor rebuilds
// each serial frame and compares it at done.
module serial_frac_alu_bench;
    localparam int FRAC_W = 30;
    localparam int W      = FRAC_W + 1;
    localparam longint MAXV = (64'sd1 <<< FRAC_W) - 1;
    localparam longint MINV = -(64'sd1 <<< FRAC_W);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op = 2'b00;
    logic       a_bit = 1'b0;
    logic       b_bit = 1'b0;
    logic       r_bit, r_valid, done, busy, sign_flag, ovf_flag;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [W-1:0] res;
        logic         ovf;
        string        req;
    } exp_t;
    exp_t exp_q[$];

    logic [W-1:0] got = '0;
    int           nbits = 0;
    logic         last_sign = 1'b0;

    always #4 clk = ~clk;

    serial_frac_alu #(.FRAC_W(FRAC_W)) u_serial_frac_alu (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .a_bit(a_bit), .b_bit(b_bit), .r_bit(r_bit), .r_valid(r_valid),
        .done(done), .busy(busy), .sign_flag(sign_flag), .ovf_flag(ovf_flag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic longint sx(input logic [W-1:0] v);
        return longint'($signed(v));
    endfunction

    // Driver: model the result, queue it, then stream the operands.
    task automatic run_op(input logic [1:0] o, input logic [W-1:0] a,
                          input logic [W-1:0] b, input string req, input bit poke);
        exp_t   e;
        longint r;
        int     k;
        if (o[1]) begin
            r = (sx(a) * sx(b)) >>> FRAC_W;
            e.ovf = (r > MAXV);
        end else begin
            r = o[0] ? sx(a) - sx(b) : sx(a) + sx(b);
            e.ovf = (r > MAXV) || (r < MINV);
        end
        e.res = r[W-1:0];
        e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
        check(!busy, "R9", "idle before start", busy, 0);
        start = 1'b1;
        op = o;
        @(negedge clk);
        start = 1'b0;
        op = ~o;
        check(busy, "R9", "busy after accepted start", busy, 1);
        check(!ovf_flag, "R8", "ovf cleared by start", ovf_flag, 0);
        check(sign_flag == last_sign, "R6", "sign held into next op", sign_flag, last_sign);
        k = 1;
        for (int i = 0; i < W; i++) begin
            a_bit = a[i];
            b_bit = b[i];
            if (poke && i == 5) begin
                start = 1'b1;
                op = 2'b10;
            end
            @(negedge clk);
            start = 1'b0;
            k++;
        end
        while (!done && k < 400) begin
            @(negedge clk);
            k++;
        end
        check(k == (o[1] ? 3*W + 2 : W + 2), "R7", "done latency", k, o[1] ? 3*W + 2 : W + 2);
        last_sign = e.res[W-1];
        @(negedge clk);
        check(!done, "R7", "done lasts one cycle", done, 0);
        check(sign_flag == last_sign, "R6", "sign held after done", sign_flag, last_sign);
    endtask

    // Monitor: collect framed bits and score each frame at done.
    always @(negedge clk) begin
        if (rst_n) begin
            if (r_valid) begin
                got = {r_bit, got[W-1:1]};
                nbits++;
            end
            if (done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "done with empty scoreboard", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(got == e.res, e.req, "result", got, e.res);
                    check(nbits == W, "R7", "bits per frame", nbits, W);
                    check(ovf_flag == e.ovf, "R4", "ovf at done", ovf_flag, e.ovf);
                    check(sign_flag == e.res[W-1], "R6", "sign at done", sign_flag, e.res[W-1]);
                end
                nbits = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R7", "watchdog expired", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] half, qtr, tqtr, neg1, ulp, nulp, maxp, nhalf;
        logic [31:0]  seed;
        half  = W'(1) << (FRAC_W - 1);
        qtr   = W'(1) << (FRAC_W - 2);
        tqtr  = half | qtr;
        neg1  = W'(1) << FRAC_W;
        ulp   = W'(1);
        nulp  = '1;
        maxp  = neg1 - 1'b1;
        nhalf = neg1 | half;

        // R1: reset state.
        repeat (3) @(negedge clk);
        check(!busy && !done && !r_valid, "R1", "controls in reset", {busy, done, r_valid}, 0);
        check(!sign_flag && !ovf_flag, "R1", "flags in reset", {sign_flag, ovf_flag}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !r_valid, "R1", "controls after reset", {busy, done, r_valid}, 0);
        check(!sign_flag && !ovf_flag, "R1", "flags after reset", {sign_flag, ovf_flag}, 0);

        run_op(2'b00, half, qtr, "R2", 1'b0);
        run_op(2'b00, nhalf, qtr, "R2", 1'b0);
        run_op(2'b00, tqtr, half, "R4", 1'b0);
        run_op(2'b00, neg1, neg1, "R4", 1'b0);
        run_op(2'b00, maxp, ulp, "R4", 1'b0);
        run_op(2'b01, qtr, tqtr, "R3", 1'b0);
        run_op(2'b01, neg1, ulp, "R4", 1'b0);
        run_op(2'b01, '0, neg1, "R4", 1'b0);
        run_op(2'b01, neg1, neg1, "R3", 1'b0);
        run_op(2'b01, half, half, "R3", 1'b0);
        run_op(2'b10, half, half, "R5", 1'b0);
        run_op(2'b10, nhalf, half, "R5", 1'b0);
        run_op(2'b10, half, nhalf | qtr, "R5", 1'b0);
        run_op(2'b10, neg1, neg1, "R5", 1'b0);
        run_op(2'b10, ulp, ulp, "R5", 1'b0);
        run_op(2'b10, nulp, ulp, "R5", 1'b0);
        run_op(2'b10, maxp, maxp, "R5", 1'b0);
        run_op(2'b11, tqtr, tqtr, "R5", 1'b0);
        run_op(2'b00, tqtr, qtr, "R9", 1'b1);
        run_op(2'b10, nhalf, tqtr, "R9", 1'b1);

        seed = 32'h1234_5678;
        for (int n = 0; n < 15; n++) begin
            logic [W-1:0] x, y;
            seed = seed * 32'd1103515245 + 32'd12345;
            x = seed[W-1:0];
            seed = seed * 32'd1103515245 + 32'd12345;
            y = seed[W-1:0];
            case (n % 3)
                0:       run_op(2'b00, x, y, "R2", 1'b0);
                1:       run_op(2'b01, x, y, "R3", 1'b0);
                default: run_op(2'b10, x, y, "R5", 1'b0);
            endcase
        end

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule